// File: doc/BRIEF.md
# Four-Channel Addressed Converter Code Latches

This block is the digital input stage of a four-channel 8-bit converter. A processor-style bus presents one 8-bit code, a 2-bit channel address and an active-low write strobe. The address is decoded into one enable per channel, and each channel holds the code that stands in for its converter input. While the strobe is low the addressed channel is open and its code tracks the bus; when the strobe returns high the channel keeps the last value it took. The other channels are never disturbed.

Two storage variants are built from one parameter. The default sampled variant fits a clocked design: on every clock edge with the strobe low the addressed channel loads the bus, so the held value after the strobe rises is the bus value from the last clock with the strobe low. The level-sensitive variant uses true latches that are open for as long as the strobe is low. In both, any invalid bus value present during the open phase reaches the channel output. For checking purposes every channel also drives an ideal unipolar level: its code as a fraction of 256 times a reference value.

Top module: `quad_dac_latch_bank`

## Requirements
- R1: A synchronous active-high reset sets all four channel codes, and so all four levels, to 0.
- R2: The address selects channel A for 00, B for 01, C for 10 and D for 11; channel A occupies bits 7:0 of the code output, B bits 15:8, C bits 23:16, D bits 31:24, and the levels are packed the same way at the reference width.
- R3: While the strobe is high no channel changes, whatever the address and data inputs do.
- R4: While the strobe is low, the addressed channel takes the bus value on each clock edge (sampled variant), so its output follows the bus one cycle later.
- R5: After the strobe rises, the addressed channel holds the bus value from the last clock edge at which the strobe was low.
- R6: A channel that is not addressed never changes, including when the address moves between channels while the strobe stays low; only the channel addressed at a given edge may load.
- R7: Invalid or changing bus data during the low phase is passed to the selected channel output and is not filtered.
- R8: Codes are straight binary with bit 7 as MSB; each channel level equals floor(code × reference / 256), giving 0 for code 0 and 255/256 of the reference for code 255.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous reset, active high |
| wr_n | input | 1 | Write strobe, active low |
| ch_addr | input | 2 | Channel address |
| bus_data | input | 8 | Shared code bus |
| ref_level | input | REF_W (12) | Reference value for the ideal level |
| chan_code | output | 32 | Four channel codes, channel A in the low byte |
| chan_level | output | 4×REF_W (48) | Four ideal unipolar levels, channel A lowest |

## Verification
On every cycle the assertions check that the decoded enables are at most one-hot and all off with the strobe high, that a channel without an enable keeps its code, that an enabled channel holds the bus value one cycle later, and that a zero code yields a zero level no higher than the reference. Only the bench scenarios show the address map end to end, that the value left after the strobe rises is the last one sampled for each of the four addresses, that glitch values during the open phase appear at the output, and that the level arithmetic is right over every code and several references.

// File: rtl/qdl_pkg.sv
package qdl_pkg;
    localparam int NCH    = 4;
    localparam int CODE_W = 8;
    localparam int ADDR_W = $clog2(NCH);

    typedef logic [CODE_W-1:0] code_t;
    typedef logic [ADDR_W-1:0] addr_t;

    typedef struct packed {
        logic  strobe_n;
        addr_t addr;
        code_t data;
    } bus_req_t;

    typedef enum logic {
        STORE_LATCH   = 1'b0,
        STORE_SAMPLED = 1'b1
    } store_kind_e;

    function automatic logic chan_hit(input bus_req_t req, input int idx);
        return (!req.strobe_n) && (req.addr == addr_t'(idx));
    endfunction
endpackage

// File: rtl/qdl_decode.sv
module qdl_decode
    import qdl_pkg::*;
(
    input  bus_req_t       req,
    output logic [NCH-1:0] sel
);
    for (genvar i = 0; i < NCH; i++) begin : g_hit
        assign sel[i] = chan_hit(req, i);
    end
endmodule

// File: rtl/qdl_channel.sv
module qdl_channel
    import qdl_pkg::*;
#(
    parameter store_kind_e KIND = STORE_SAMPLED
) (
    input  logic  clk,
    input  logic  rst,
    input  logic  load,
    input  code_t din,
    output code_t code
);
    if (KIND == STORE_SAMPLED) begin : g_sampled
        always_ff @(posedge clk) begin
            if (rst)       code <= '0;
            else if (load) code <= din;
        end

        // R4 R7: an enabled channel shows the bus value from the previous edge
        assert_follow_bus_R4: assert property (@(posedge clk) disable iff (rst)
            (!$past(rst) && $past(load)) |-> (code == $past(din)));
    end else begin : g_level
        always_latch begin
            if (rst)       code <= '0;
            else if (load) code <= din;
        end
    end

    // R3 R6: without an enable the stored code does not move
    assert_hold_when_closed_R6: assert property (@(posedge clk) disable iff (rst)
        (!$past(rst) && !$past(load) && !load) |-> $stable(code));
endmodule

// File: rtl/qdl_level.sv
module qdl_level
    import qdl_pkg::*;
#(
    parameter int REF_W = 12
) (
    input  code_t             code,
    input  logic [REF_W-1:0]  ref_level,
    output logic [REF_W-1:0]  level
);
    localparam int PROD_W = CODE_W + REF_W;

    logic [PROD_W-1:0] prod;

    always_comb begin
        prod  = PROD_W'(code) * PROD_W'(ref_level);
        level = prod[PROD_W-1:CODE_W];
    end
endmodule

// File: rtl/quad_dac_latch_bank.sv
module quad_dac_latch_bank
    import qdl_pkg::*;
#(
    parameter int          REF_W = 12,
    parameter store_kind_e KIND  = STORE_SAMPLED
) (
    input  logic                   clk,
    input  logic                   rst,
    input  logic                   wr_n,
    input  logic [ADDR_W-1:0]      ch_addr,
    input  logic [CODE_W-1:0]      bus_data,
    input  logic [REF_W-1:0]       ref_level,
    output logic [NCH*CODE_W-1:0]  chan_code,
    output logic [NCH*REF_W-1:0]   chan_level
);
    bus_req_t       req;
    logic [NCH-1:0] sel;

    always_comb begin
        req.strobe_n = wr_n;
        req.addr     = ch_addr;
        req.data     = bus_data;
    end

    qdl_decode u_decode (
        .req (req),
        .sel (sel)
    );

    for (genvar i = 0; i < NCH; i++) begin : g_chan
        code_t             code_i;
        logic [REF_W-1:0]  level_i;

        qdl_channel #(.KIND(KIND)) u_chan (
            .clk  (clk),
            .rst  (rst),
            .load (sel[i]),
            .din  (req.data),
            .code (code_i)
        );

        qdl_level #(.REF_W(REF_W)) u_level (
            .code      (code_i),
            .ref_level (ref_level),
            .level     (level_i)
        );

        assign chan_code[i*CODE_W +: CODE_W] = code_i;
        assign chan_level[i*REF_W +: REF_W]  = level_i;

        // R8: zero code gives zero level, and no level exceeds the reference
        assert_level_zero_R8: assert property (@(posedge clk) disable iff (rst)
            (code_i == '0) |-> (level_i == '0));
        assert_level_bound_R8: assert property (@(posedge clk) disable iff (rst)
            level_i <= ref_level);
    end

    // R6: at most one channel is open at any time
    assert_single_open_R6: assert property (@(posedge clk) disable iff (rst)
        $onehot0(sel));
    // R3: strobe high opens nothing
    assert_idle_closed_R3: assert property (@(posedge clk) disable iff (rst)
        wr_n |-> (sel == '0));
    // R2: the open channel is the addressed one
    assert_addr_map_R2: assert property (@(posedge clk) disable iff (rst)
        !wr_n |-> sel[ch_addr]);
endmodule

// File: tb/tb_quad_dac_latch_bank.sv
module tb_quad_dac_latch_bank;
    localparam int REF_W = 12;

    logic              clk = 1'b0;
    logic              rst;
    logic              wr_n;
    logic [1:0]        ch_addr;
    logic [7:0]        bus_data;
    logic [REF_W-1:0]  ref_level;
    logic [31:0]       chan_code;
    logic [4*REF_W-1:0] chan_level;

    int checks = 0;
    int errors = 0;
    logic [7:0] exp_code [4];

    always #5 clk = ~clk;

    quad_dac_latch_bank #(.REF_W(REF_W)) dut (
        .clk        (clk),
        .rst        (rst),
        .wr_n       (wr_n),
        .ch_addr    (ch_addr),
        .bus_data   (bus_data),
        .ref_level  (ref_level),
        .chan_code  (chan_code),
        .chan_level (chan_level)
    );

    task automatic check_all(input string tag);
        for (int i = 0; i < 4; i++) begin
            logic [7:0]       got_c;
            logic [REF_W-1:0] got_l;
            logic [REF_W-1:0] want_l;
            got_c  = chan_code[i*8 +: 8];
            got_l  = chan_level[i*REF_W +: REF_W];
            want_l = REF_W'((int'(exp_code[i]) * int'(ref_level)) / 256);
            checks++;
            if (got_c !== exp_code[i]) begin
                errors++;
                $display("FAIL %s ch%0d code actual=%0h expected=%0h", tag, i, got_c, exp_code[i]);
            end
            checks++;
            if (got_l !== want_l) begin
                errors++;
                $display("FAIL %s R8 ch%0d level actual=%0d expected=%0d", tag, i, got_l, want_l);
            end
        end
    endtask

    // drive at the falling edge, model the rising edge, sample after it
    task automatic step(input logic s_n, input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        wr_n = s_n; ch_addr = a; bus_data = d;
        @(posedge clk);
        if (!s_n) exp_code[a] = d;
        #1;
    endtask

    initial begin
        #150000;
        errors++;
        $display("FAIL watchdog expired");
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        rst = 1'b1; wr_n = 1'b1; ch_addr = '0; bus_data = 8'h5A; ref_level = 12'd2560;
        for (int i = 0; i < 4; i++) exp_code[i] = '0;
        repeat (3) @(posedge clk);
        #1;
        check_all("R1 reset");
        @(negedge clk); rst = 1'b0;

        // R2 R5: write each address, then check the held value after the strobe rises
        for (int a = 0; a < 4; a++) begin
            for (int k = 0; k < 8; k++) begin
                step(1'b0, 2'(a), 8'(a * 37 + k * 53 + 1));
                step(1'b1, 2'(a), 8'(~(a * 37 + k * 53)));
                check_all("R2 R5 held after strobe rise");
            end
        end

        // R3: strobe high, sweep every address and many data values
        for (int a = 0; a < 4; a++) begin
            for (int d = 0; d < 256; d += 17) begin
                step(1'b1, 2'(a), 8'(d));
            end
            check_all("R3 idle sweep");
        end

        // R4 R7: glitching bus during one low phase reaches the output each cycle
        step(1'b0, 2'd2, 8'h11); check_all("R4 follow 1");
        step(1'b0, 2'd2, 8'hEE); check_all("R7 glitch visible");
        step(1'b0, 2'd2, 8'h3C); check_all("R4 follow 3");
        step(1'b1, 2'd2, 8'hFF); check_all("R5 last low value kept");

        // R6: address moves while the strobe stays low
        step(1'b0, 2'd0, 8'hA1);
        step(1'b0, 2'd1, 8'hB2); check_all("R6 move A to B");
        step(1'b0, 2'd3, 8'hD4); check_all("R6 move B to D");
        step(1'b1, 2'd2, 8'h00); check_all("R6 others untouched");

        // R8: every code with several references on channel B
        foreach (exp_code[i]) begin end
        for (int r = 0; r < 4; r++) begin
            @(negedge clk);
            ref_level = (r == 0) ? 12'd0 : (r == 1) ? 12'd4095 : (r == 2) ? 12'd2560 : 12'd1000;
            for (int c = 0; c < 256; c++) begin
                step(1'b0, 2'd1, 8'(c));
                if (c == 0 || c == 1 || c == 128 || c == 255 || (c % 16) == 7)
                    check_all("R8 level sweep");
            end
            step(1'b1, 2'd1, 8'h00);
            check_all("R8 final held");
        end

        // R1: reset after activity clears everything
        @(negedge clk); rst = 1'b1; wr_n = 1'b0; ch_addr = 2'd3; bus_data = 8'h77;
        @(posedge clk);
        for (int i = 0; i < 4; i++) exp_code[i] = '0;
        #1;
        check_all("R1 reset after use");
        @(negedge clk); rst = 1'b0; wr_n = 1'b1;
        step(1'b1, 2'd0, 8'h00);
        check_all("R1 cleared state held");

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule